// File: doc/BRIEF.md
# Restart and Interrupt Vector Controller

This block sits beside an 8-bit processor core's sequencer and turns two kinds of event into a call target. The first kind is a software restart: the core decodes a one-byte restart and presents its 3-bit number. The second kind is a hardware request on one of five lines. These are a non-maskable line, three internally vectored lines with individual mask bits, and a general request line whose vector is a build-time constant. The block also owns the flip-flop that enables the maskable interrupts.

Each cycle the block selects at most one event and registers the result. It outputs a one-cycle vector strobe with the 16-bit target. It raises an acknowledge pulse when a hardware request was taken. It raises a wake pulse when that acceptance happens while the core reports a halt. The core stays responsible for pushing the return address onto the stack. A combinational status byte serves the core's read-mask operation.

Top module: `intr_vector_ctrl`

## Requirements
- R1: A software restart with number n (0..7) gives one cycle of `vec_valid_o` with `vec_o` = n*8 (0000h..0038h) one clock after the request. `ack_o` stays low and the enable state does not change.
- R2: The hardware vectors are fixed: non-maskable line 0024h, line 7.5 003Ch, line 6.5 0034h, line 5.5 002Ch.
- R3: When several requests are eligible, the order of preference is non-maskable, 7.5, 6.5, 5.5, then general. Each acceptance produces exactly one vector together with one `ack_o` pulse.
- R4: The non-maskable line is accepted whatever the enable state and the mask bits are.
- R5: `ie_clr_i` clears the enable state, and `ie_set_i` sets it. While the enable state is low, no maskable line is accepted. Clear wins over set.
- R6: Reset clears the enable state. Every hardware acceptance also clears it, even when `ie_set_i` is high in the same cycle.
- R7: The non-maskable line and line 7.5 are edge-triggered. A rising edge is remembered until that line is accepted. A level held high after acceptance does not fire again.
- R8: Lines 6.5 and 5.5 are level-sensitive. Lines 7.5, 6.5 and 5.5 are blocked while their mask bit is 1 (`mask_i[2]`, `mask_i[1]`, `mask_i[0]`). A masked 7.5 edge stays pending.
- R9: `status_o` holds masks 5.5/6.5/7.5 in bits 0..2, the enable state in bit 3, and pending 5.5/6.5/7.5 in bits 4..6. Bit 7 holds `sid_i`. Pending 6.5 and 5.5 are the raw line levels. Pending 7.5 is the stored edge.
- R10: `wake_o` pulses together with `ack_o` when `halted_i` was high in the accepting cycle. It stays low otherwise.
- R11: If a software restart and an eligible hardware request coincide, the restart is issued first. The hardware request is issued in the following cycle.
- R12: The general request line vectors to the parameter `INTR_VEC` (default 0038h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| swrst_req_i | input | 1 | Software restart request |
| swrst_num_i | input | 3 | Restart number |
| ie_set_i | input | 1 | Enable-interrupts command |
| ie_clr_i | input | 1 | Disable-interrupts command |
| halted_i | input | 1 | Core is in halt state |
| nmi_i | input | 1 | Non-maskable request, edge-triggered |
| r75_i | input | 1 | Line 7.5, edge-triggered |
| r65_i | input | 1 | Line 6.5, level |
| r55_i | input | 1 | Line 5.5, level |
| intr_i | input | 1 | General request, level |
| mask_i | input | 3 | Masks for 5.5, 6.5, 7.5 (bit 0..2), 1 = blocked |
| sid_i | input | 1 | Serial input bit |
| vec_valid_o | output | 1 | Vector strobe |
| vec_o | output | 16 | Call target address |
| ack_o | output | 1 | Hardware request accepted |
| ie_o | output | 1 | Enable state |
| wake_o | output | 1 | Leave halt |
| status_o | output | 8 | Read-mask status byte |

## Verification
The bench builds the block with its default parameters: 16-bit vectors, a 3-bit restart number and `INTR_VEC` = 0038h. With these settings every restart number can be swept. All 32 combinations of the five request lines are crossed with all 8 mask settings, so every priority pairing, every masked or pending 7.5 case and the status byte after each acceptance are checked against a winner that the bench computes. Directed sequences cover enable and disable ordering, the edge memory and the case where a restart and an interrupt collide.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned VEC_W  = 16;
  localparam int unsigned NUM_W  = 3;
  localparam int unsigned NSRC   = 5;
  localparam int unsigned SRC_W  = $clog2(NSRC);

  // index = preference rank, 0 wins
  localparam int unsigned S_NMI  = 0;
  localparam int unsigned S_R75  = 1;
  localparam int unsigned S_R65  = 2;
  localparam int unsigned S_R55  = 3;
  localparam int unsigned S_INTR = 4;

  localparam logic [VEC_W-1:0] VEC_NMI = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_R75 = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_R65 = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_R55 = 16'h002C;

  function automatic logic [VEC_W-1:0] sw_vec(input logic [NUM_W-1:0] n);
    sw_vec = '0;
    sw_vec[NUM_W+2:3] = n;
  endfunction
endpackage

// File: rtl/ivc_edge_latch.sv
module ivc_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic take_i,
  output logic hit_o,
  output logic pend_o
);
  logic prev_q, lat_q, rise;

  assign rise   = lvl_i & ~prev_q;
  assign hit_o  = lat_q | rise;
  assign pend_o = lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      lat_q  <= take_i ? 1'b0 : (lat_q | rise);
    end
  end
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
  parameter int unsigned N = 5,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  gnt_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;

  for (genvar g = 0; g < N; g++) begin : g_gnt
    assign gnt_o[g] = any_o && (idx_o == IW'(g));
  end
endmodule

// File: rtl/ivc_ie_ff.sv
module ivc_ie_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic ie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ie_o <= 1'b0;
    else if (ack_i || clr_i)  ie_o <= 1'b0;
    else if (set_i)           ie_o <= 1'b1;
  end
endmodule

// File: rtl/intr_vector_ctrl.sv
module intr_vector_ctrl
  import ivc_pkg::*;
#(
  parameter logic [VEC_W-1:0] INTR_VEC = 16'h0038
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             swrst_req_i,
  input  logic [NUM_W-1:0] swrst_num_i,
  input  logic             ie_set_i,
  input  logic             ie_clr_i,
  input  logic             halted_i,
  input  logic             nmi_i,
  input  logic             r75_i,
  input  logic             r65_i,
  input  logic             r55_i,
  input  logic             intr_i,
  input  logic [2:0]       mask_i,
  input  logic             sid_i,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ack_o,
  output logic             ie_o,
  output logic             wake_o,
  output logic [7:0]       status_o
);
  logic [1:0]      edge_lvl, edge_take, edge_hit, edge_pend;
  logic [NSRC-1:0] elig, gnt;
  logic [SRC_W-1:0] win;
  logic            hw_any, accept;
  logic [VEC_W-1:0] hw_vec;

  assign edge_lvl = {r75_i, nmi_i};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    ivc_edge_latch i_lat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (edge_lvl[g]),
      .take_i (edge_take[g]),
      .hit_o  (edge_hit[g]),
      .pend_o (edge_pend[g])
    );
  end

  assign elig[S_NMI]  = edge_hit[0];
  assign elig[S_R75]  = ie_o & edge_hit[1] & ~mask_i[2];
  assign elig[S_R65]  = ie_o & r65_i & ~mask_i[1];
  assign elig[S_R55]  = ie_o & r55_i & ~mask_i[0];
  assign elig[S_INTR] = ie_o & intr_i;

  ivc_prio #(.N(NSRC)) i_prio (
    .req_i (elig),
    .any_o (hw_any),
    .idx_o (win),
    .gnt_o (gnt)
  );

  // restart takes the slot; hardware requests stay eligible
  assign accept    = hw_any & ~swrst_req_i;
  assign edge_take = {accept & gnt[S_R75], accept & gnt[S_NMI]};

  always_comb begin
    case (win)
      SRC_W'(S_NMI): hw_vec = VEC_NMI;
      SRC_W'(S_R75): hw_vec = VEC_R75;
      SRC_W'(S_R65): hw_vec = VEC_R65;
      SRC_W'(S_R55): hw_vec = VEC_R55;
      default:       hw_vec = INTR_VEC;
    endcase
  end

  ivc_ie_ff i_ie (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ie_set_i),
    .clr_i  (ie_clr_i),
    .ack_i  (accept),
    .ie_o   (ie_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
      ack_o       <= 1'b0;
      wake_o      <= 1'b0;
    end else begin
      vec_valid_o <= swrst_req_i | accept;
      ack_o       <= accept;
      wake_o      <= accept & halted_i;
      if (swrst_req_i)  vec_o <= sw_vec(swrst_num_i);
      else if (accept)  vec_o <= hw_vec;
    end
  end

  assign status_o = {sid_i, edge_pend[1], r65_i, r55_i, ie_o, mask_i};
endmodule

// File: rtl/ivc_chk.sv
module ivc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ie_clr_i,
  input logic        vec_valid_o,
  input logic [15:0] vec_o,
  input logic        ack_o,
  input logic        ie_o,
  input logic        wake_o
);
  // R3
  ack_has_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> vec_valid_o);

  // R6
  ack_drops_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !ie_o);

  // R5
  clr_drops_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_clr_i |=> !ie_o);

  // R4
  nmi_only_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !$past(ie_o)) |-> (vec_o == 16'h0024));

  // R1
  sw_vec_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && !ack_o) |-> (vec_o[15:6] == '0 && vec_o[2:0] == '0));

  // R10
  wake_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ack_o);
endmodule

bind intr_vector_ctrl ivc_chk i_ivc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ie_clr_i    (ie_clr_i),
  .vec_valid_o (vec_valid_o),
  .vec_o       (vec_o),
  .ack_o       (ack_o),
  .ie_o        (ie_o),
  .wake_o      (wake_o)
);

// File: tb/test_intr_vector_ctrl.sv
module test_intr_vector_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        swrst_req_i = 0, ie_set_i = 0, ie_clr_i = 0, halted_i = 0;
  logic [2:0]  swrst_num_i = 0, mask_i = 0;
  logic        nmi_i = 0, r75_i = 0, r65_i = 0, r55_i = 0, intr_i = 0, sid_i = 0;
  logic        vec_valid_o, ack_o, ie_o, wake_o;
  logic [15:0] vec_o;
  logic [7:0]  status_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  intr_vector_ctrl i_intr_vector_ctrl (.*);

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    swrst_req_i = 0; ie_set_i = 0; ie_clr_i = 0; halted_i = 0;
    nmi_i = 0; r75_i = 0; r65_i = 0; r55_i = 0; intr_i = 0;
    mask_i = 0; sid_i = 0; swrst_num_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i); clear_in(); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic ie_on();
    ie_set_i = 1; @(negedge clk_i); ie_set_i = 0;
  endtask

  function automatic logic [15:0] winner(input logic [4:0] rq, input logic [2:0] m);
    if (rq[4])              return 16'h0024;
    if (rq[3] && !m[2])     return 16'h003C;
    if (rq[2] && !m[1])     return 16'h0034;
    if (rq[1] && !m[0])     return 16'h002C;
    if (rq[0])              return 16'h0038;
    return 16'h0000;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R6 reset state
    chk(!vec_valid_o && !ack_o && !wake_o && !ie_o && status_o == 8'h00, "R6 reset",
        {vec_valid_o, ack_o, wake_o, ie_o, 4'h0, status_o}, 16'h0);

    // R1 all restart numbers, enable state held
    ie_on();
    for (int n = 0; n < 8; n++) begin
      swrst_req_i = 1; swrst_num_i = 3'(n);
      @(negedge clk_i); swrst_req_i = 0;
      chk(vec_valid_o && !ack_o && ie_o && vec_o == 16'(n * 8), "R1 restart", vec_o, 16'(n * 8));
      @(negedge clk_i);
      chk(!vec_valid_o, "R1 one cycle", {15'h0, vec_valid_o}, 16'h0);
    end

    // R2 R3 R8 R9 R10 R12 sweep of request lines x masks
    for (int rq = 0; rq < 32; rq++) begin
      for (int m = 0; m < 8; m++) begin
        logic [15:0] ev;
        logic [7:0]  es;
        bit          hlt;
        do_reset();
        ie_on();
        ev  = winner(5'(rq), 3'(m));
        hlt = rq[0] ^ m[1];
        nmi_i = rq[4]; r75_i = rq[3]; r65_i = rq[2]; r55_i = rq[1]; intr_i = rq[0];
        mask_i = 3'(m); sid_i = m[0]; halted_i = hlt;
        @(negedge clk_i);
        if (ev != 0)
          chk(vec_valid_o && ack_o && vec_o == ev && wake_o == hlt, "R3 winner", vec_o, ev);
        else
          chk(!vec_valid_o && !ack_o && !wake_o, "R8 none eligible", vec_o, 16'h0);
        @(negedge clk_i);
        chk(!vec_valid_o, "R3 single vector", {15'h0, vec_valid_o}, 16'h0);
        es = {m[0], rq[3] && ev != 16'h003C, rq[2], rq[1], ev == 0, 3'(m)};
        chk(status_o == es, "R9 status", {8'h0, status_o}, {8'h0, es});
        clear_in();
      end
    end

    // R4 non-maskable with enable off
    do_reset();
    r65_i = 1; r55_i = 1; intr_i = 1;
    @(negedge clk_i); @(negedge clk_i);
    chk(!vec_valid_o && !ie_o, "R4 maskable blocked", vec_o, 16'h0);
    nmi_i = 1; mask_i = 3'b111;
    @(negedge clk_i);
    chk(ack_o && vec_o == 16'h0024, "R4 nmi taken", vec_o, 16'h0024);
    clear_in();

    // R5 enable / disable
    do_reset();
    ie_on();
    chk(ie_o, "R5 set", {15'h0, ie_o}, 16'h1);
    ie_clr_i = 1; ie_set_i = 1;
    @(negedge clk_i); ie_clr_i = 0; ie_set_i = 0;
    chk(!ie_o, "R5 clear wins", {15'h0, ie_o}, 16'h0);
    intr_i = 1;
    @(negedge clk_i); @(negedge clk_i);
    chk(!vec_valid_o, "R5 blocked when off", vec_o, 16'h0);
    intr_i = 0;

    // R6 acceptance beats a simultaneous set
    ie_on();
    intr_i = 1; ie_set_i = 1;
    @(negedge clk_i); intr_i = 0; ie_set_i = 0;
    chk(ack_o && vec_o == 16'h0038 && !ie_o, "R6 ack clears", {15'h0, ie_o}, 16'h0);

    // R7 short 7.5 pulse remembered
    do_reset();
    r75_i = 1; @(negedge clk_i); r75_i = 0;
    @(negedge clk_i); @(negedge clk_i);
    chk(status_o[6] && !vec_valid_o, "R7 pending kept", {8'h0, status_o}, 16'h0040);
    ie_on();
    @(negedge clk_i);
    chk(ack_o && vec_o == 16'h003C, "R7 late accept", vec_o, 16'h003C);
    chk(!status_o[6], "R7 pending cleared", {8'h0, status_o}, 16'h0);
    // R7 held level does not refire
    r75_i = 1; ie_on();
    @(negedge clk_i);
    chk(ack_o && vec_o == 16'h003C, "R7 held first", vec_o, 16'h003C);
    ie_on();
    @(negedge clk_i); @(negedge clk_i);
    chk(!vec_valid_o && ie_o, "R7 held no refire", vec_o, 16'h0);
    clear_in();

    // R11 restart collides with request
    do_reset();
    ie_on();
    intr_i = 1; swrst_req_i = 1; swrst_num_i = 3'd5;
    @(negedge clk_i); swrst_req_i = 0;
    chk(vec_valid_o && !ack_o && vec_o == 16'h0028, "R11 restart first", vec_o, 16'h0028);
    @(negedge clk_i); intr_i = 0;
    chk(ack_o && vec_o == 16'h0038, "R11 request next", vec_o, 16'h0038);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule